// File: doc/BRIEF.md
# DMA Channel Interrupt Controller

This block holds the interrupt state of a single DMA channel. The transfer engine sends it single-cycle event pulses: a bus-error abort, the end of a block, the end of a circular pass, and the midpoint of a circular pass. The block latches each event into a sticky status flag. Software clears a flag by writing 1 to its position in the status register. The block also holds a three-bit enable register. It combines the flags with the enables into one registered interrupt line, and that line can also be read back through the status register.

Circular-buffer transfers can interrupt at the midpoint of a pass, at its end, or at both. A four-bit selection field chooses which of these events count: bit 0 covers end-of-pass and bit 2 covers midpoint. Wrap events are honoured only while the channel reports that its source or destination address is in wrap mode. This lets software refill one half of a ring while the engine drains the other half.

Top module: `dma_irq_ctrl`

## Requirements
- R1: After a synchronous active-high reset, the enable register, every status flag and `irq_o` are 0.
- R2: A cycle with `en_we` high loads `en_wdata` into the enable register. From the next cycle, `en_rdata` returns that value. Bit 0 enables abort, bit 1 enables done and bit 2 enables wrap.
- R3: An `evt_abort` pulse sets status bit 0 and an `evt_done` pulse sets status bit 1, whatever the enables hold.
- R4: An `evt_wrap_full` pulse sets status bit 8 only when `wrap_mode_on` is 1 and `wrap_sel[0]` is 1. An `evt_wrap_half` pulse sets status bit 10 only when `wrap_mode_on` is 1 and `wrap_sel[2]` is 1. In every other case these pulses have no effect.
- R5: A cycle with `sts_we` high clears each flag whose bit in `sts_wdata` is 1. Flags whose bit is 0 keep their value. All other status bits always read 0, except bit 31.
- R6: If an event and a clear hit the same flag in the same cycle, the flag is set after that cycle.
- R7: `irq_o` is registered. In the cycle after edge N it equals (abort flag AND enable bit 0) OR (done flag AND enable bit 1) OR (enable bit 2 AND `wrap_mode_on` AND ((end flag AND `wrap_sel[0]`) OR (midpoint flag AND `wrap_sel[2]`))). The flags and enables in this expression are the values held before edge N. `wrap_mode_on` and `wrap_sel` are the values present at edge N.
- R8: Status bit 31 always equals `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_abort | input | 1 | Bus-error abort pulse from the engine |
| evt_done | input | 1 | Block-complete pulse |
| evt_wrap_full | input | 1 | Circular pass complete pulse |
| evt_wrap_half | input | 1 | Circular pass midpoint pulse |
| wrap_sel | input | SEL_W | Wrap event selection (bit 0 end, bit 2 midpoint) |
| wrap_mode_on | input | 1 | Source or destination address is in wrap mode |
| en_we | input | 1 | Enable register write strobe |
| en_wdata | input | EN_W | Enable register write data |
| sts_we | input | 1 | Status register write strobe (write 1 to clear) |
| sts_wdata | input | DATA_W | Status register write data |
| en_rdata | output | EN_W | Enable register contents |
| sts_rdata | output | DATA_W | Status flags with the interrupt line in bit 31 |
| irq_o | output | 1 | Registered channel interrupt |

## Verification
The same flag can receive an engine event and a software write-1-to-clear in the same cycle. The bench provokes this in two ways: a directed cycle that pulses abort while writing all ones to the status register, and a sweep that drives events and clear masks together across every enable, selection and mode combination. In every collision the flag must read back set at the next sample. The sweep also runs each flag through a clear-only cycle, where the flag must drop, so a design that lets the clear win or ignores the clear is caught.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  // Status register bit positions
  localparam int ABT_POS   = 0;
  localparam int DONE_POS  = 1;
  localparam int WFULL_POS = 8;
  localparam int WHALF_POS = 10;
  localparam int IRQ_POS   = 31;
  // Selection field bits
  localparam int SEL_FULL  = 0;
  localparam int SEL_HALF  = 2;
  // Flag indices inside the flag vector
  localparam int NFLAGS    = 4;
  localparam int F_ABT     = 0;
  localparam int F_DONE    = 1;
  localparam int F_WFULL   = 2;
  localparam int F_WHALF   = 3;
  // Enable bit indices
  localparam int E_ABT     = 0;
  localparam int E_DONE    = 1;
  localparam int E_WRAP    = 2;

  function automatic int flag_pos(input int idx);
    case (idx)
      F_ABT:   return ABT_POS;
      F_DONE:  return DONE_POS;
      F_WFULL: return WFULL_POS;
      default: return WHALF_POS;
    endcase
  endfunction
endpackage

// File: rtl/dma_irq_flag.sv
module dma_irq_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk) begin
    if (rst) q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
    else if (clr_i) q_o <= 1'b0;
  end

  // R6
  evt_wins_chk: assert property (@(posedge clk) disable iff (rst) set_i |=> q_o);
  // R5
  clr_drop_chk: assert property (@(posedge clk) disable iff (rst) (clr_i && !set_i) |=> !q_o);
  // R5
  hold_chk: assert property (@(posedge clk) disable iff (rst) (!clr_i && !set_i) |=> $stable(q_o));
endmodule

// File: rtl/dma_irq_enable.sv
module dma_irq_enable #(
  parameter int EN_W = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we_i,
  input  logic [EN_W-1:0] wdata_i,
  output logic [EN_W-1:0] q_o
);
  always_ff @(posedge clk) begin
    if (rst) q_o <= '0;
    else if (we_i) q_o <= wdata_i;
  end

  // R2
  en_load_chk: assert property (@(posedge clk) disable iff (rst) we_i |=> (q_o == $past(wdata_i)));
  // R2
  en_keep_chk: assert property (@(posedge clk) disable iff (rst) !we_i |=> $stable(q_o));
endmodule

// File: rtl/dma_irq_merge.sv
module dma_irq_merge
  import dma_irq_pkg::*;
#(
  parameter int EN_W  = 3,
  parameter int SEL_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NFLAGS-1:0] flags_i,
  input  logic [EN_W-1:0]   en_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic              wrap_mode_i,
  output logic              irq_o
);
  logic wrap_src;
  logic irq_src;

  always_comb begin
    wrap_src = en_i[E_WRAP] & wrap_mode_i &
               ((flags_i[F_WFULL] & sel_i[SEL_FULL]) |
                (flags_i[F_WHALF] & sel_i[SEL_HALF]));
    irq_src  = (flags_i[F_ABT] & en_i[E_ABT]) |
               (flags_i[F_DONE] & en_i[E_DONE]) | wrap_src;
  end

  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else irq_o <= irq_src;
  end

  // R7
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (rst) irq_o |-> ($past(flags_i) != '0));
  // R7
  irq_needs_en_chk: assert property (@(posedge clk) disable iff (rst) irq_o |-> ($past(en_i) != '0));
endmodule

// File: rtl/dma_irq_ctrl.sv
module dma_irq_ctrl
  import dma_irq_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int EN_W   = 3,
  parameter int SEL_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              evt_abort,
  input  logic              evt_done,
  input  logic              evt_wrap_full,
  input  logic              evt_wrap_half,
  input  logic [SEL_W-1:0]  wrap_sel,
  input  logic              wrap_mode_on,
  input  logic              en_we,
  input  logic [EN_W-1:0]   en_wdata,
  input  logic              sts_we,
  input  logic [DATA_W-1:0] sts_wdata,
  output logic [EN_W-1:0]   en_rdata,
  output logic [DATA_W-1:0] sts_rdata,
  output logic              irq_o
);
  logic [NFLAGS-1:0] set_v;
  logic [NFLAGS-1:0] clr_v;
  logic [NFLAGS-1:0] flag_q;
  logic              unused_wbits;

  assign unused_wbits = ^sts_wdata;

  always_comb begin
    set_v[F_ABT]   = evt_abort;
    set_v[F_DONE]  = evt_done;
    set_v[F_WFULL] = evt_wrap_full & wrap_mode_on & wrap_sel[SEL_FULL];
    set_v[F_WHALF] = evt_wrap_half & wrap_mode_on & wrap_sel[SEL_HALF];
  end

  for (genvar i = 0; i < NFLAGS; i++) begin : g_flag
    assign clr_v[i] = sts_we & sts_wdata[flag_pos(i)];
    dma_irq_flag u_flag (
      .clk   (clk),
      .rst   (rst),
      .set_i (set_v[i]),
      .clr_i (clr_v[i]),
      .q_o   (flag_q[i])
    );
  end

  dma_irq_enable #(.EN_W(EN_W)) u_en (
    .clk     (clk),
    .rst     (rst),
    .we_i    (en_we),
    .wdata_i (en_wdata),
    .q_o     (en_rdata)
  );

  dma_irq_merge #(.EN_W(EN_W), .SEL_W(SEL_W)) u_merge (
    .clk         (clk),
    .rst         (rst),
    .flags_i     (flag_q),
    .en_i        (en_rdata),
    .sel_i       (wrap_sel),
    .wrap_mode_i (wrap_mode_on),
    .irq_o       (irq_o)
  );

  always_comb begin
    sts_rdata = '0;
    for (int i = 0; i < NFLAGS; i++) sts_rdata[flag_pos(i)] = flag_q[i];
    sts_rdata[IRQ_POS] = irq_o;
  end

  // R4
  wfull_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (!wrap_mode_on && !sts_rdata[WFULL_POS]) |=> !sts_rdata[WFULL_POS]);
  // R4
  whalf_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (!wrap_sel[SEL_HALF] && !sts_rdata[WHALF_POS]) |=> !sts_rdata[WHALF_POS]);
  // R3
  abort_set_chk: assert property (@(posedge clk) disable iff (rst) evt_abort |=> sts_rdata[ABT_POS]);
  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> (!irq_o && flag_q == '0 && en_rdata == '0));
endmodule

// File: tb/dma_irq_ctrl_tb.sv
module dma_irq_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        evt_abort = 0, evt_done = 0, evt_wrap_full = 0, evt_wrap_half = 0;
  logic [3:0]  wrap_sel = '0;
  logic        wrap_mode_on = 0;
  logic        en_we = 0;
  logic [2:0]  en_wdata = '0;
  logic        sts_we = 0;
  logic [31:0] sts_wdata = '0;
  logic [2:0]  en_rdata;
  logic [31:0] sts_rdata;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  bit done_run = 0;

  // model state
  logic m_ab = 0, m_dn = 0, m_wf = 0, m_wh = 0, m_irq = 0;
  logic [2:0] m_en = '0;

  always #2 clk = ~clk;

  dma_irq_ctrl u_dut (
    .clk(clk), .rst(rst),
    .evt_abort(evt_abort), .evt_done(evt_done),
    .evt_wrap_full(evt_wrap_full), .evt_wrap_half(evt_wrap_half),
    .wrap_sel(wrap_sel), .wrap_mode_on(wrap_mode_on),
    .en_we(en_we), .en_wdata(en_wdata),
    .sts_we(sts_we), .sts_wdata(sts_wdata),
    .en_rdata(en_rdata), .sts_rdata(sts_rdata), .irq_o(irq_o)
  );

  function automatic logic [31:0] exp_sts();
    logic [31:0] v = '0;
    v[0] = m_ab; v[1] = m_dn; v[8] = m_wf; v[10] = m_wh; v[31] = m_irq;
    return v;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Called at a negedge: drive, wait one edge, update model, compare at next negedge
  task automatic step(input logic [3:0] ev, input logic [3:0] sel, input logic mode,
                      input logic ewe, input logic [2:0] ed,
                      input logic swe, input logic [31:0] sd);
    logic clr_ab, clr_dn, clr_wf, clr_wh;
    evt_abort = ev[0]; evt_done = ev[1]; evt_wrap_full = ev[2]; evt_wrap_half = ev[3];
    wrap_sel = sel; wrap_mode_on = mode;
    en_we = ewe; en_wdata = ed; sts_we = swe; sts_wdata = sd;
    @(negedge clk);
    // R7 expectation uses flags and enables from before the edge
    m_irq = (m_ab & m_en[0]) | (m_dn & m_en[1]) |
            (m_en[2] & mode & ((m_wf & sel[0]) | (m_wh & sel[2])));
    clr_ab = swe & sd[0]; clr_dn = swe & sd[1]; clr_wf = swe & sd[8]; clr_wh = swe & sd[10];
    m_ab = ev[0] | (m_ab & ~clr_ab);
    m_dn = ev[1] | (m_dn & ~clr_dn);
    m_wf = (ev[2] & mode & sel[0]) | (m_wf & ~clr_wf);
    m_wh = (ev[3] & mode & sel[2]) | (m_wh & ~clr_wh);
    if (ewe) m_en = ed;
    evt_abort = 0; evt_done = 0; evt_wrap_full = 0; evt_wrap_half = 0;
    en_we = 0; sts_we = 0;
    chk("R3 R4 R5 R6 status flags", {1'b0, sts_rdata[30:0]}, {1'b0, exp_sts() & 32'h7FFF_FFFF});
    chk("R7 irq_o", {31'd0, irq_o}, {31'd0, m_irq});
    chk("R8 status bit31", {31'd0, sts_rdata[31]}, {31'd0, irq_o});
    chk("R2 enable readback", {29'd0, en_rdata}, {29'd0, m_en});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_run) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: reset state
    chk("R1 status after reset", sts_rdata, 32'h0);
    chk("R1 enable after reset", {29'd0, en_rdata}, 32'h0);
    chk("R1 irq after reset", {31'd0, irq_o}, 32'h0);

    // R3: events set flags with all enables off
    step(4'b0011, 4'h0, 1'b0, 1'b0, 3'b000, 1'b0, 32'h0);
    // R5: writing zeros leaves flags alone
    step(4'b0000, 4'h0, 1'b0, 1'b0, 3'b000, 1'b1, 32'h0);
    chk("R5 zero write keeps flags", {30'd0, sts_rdata[1:0]}, 32'h3);
    // R6: abort event collides with clear of every flag
    step(4'b0001, 4'h0, 1'b0, 1'b0, 3'b000, 1'b1, 32'hFFFF_FFFF);
    chk("R6 event beats clear", {31'd0, sts_rdata[0]}, 32'h1);
    // R4: wrap events ignored while not in wrap mode
    step(4'b1100, 4'hF, 1'b0, 1'b0, 3'b000, 1'b1, 32'hFFFF_FFFF);
    chk("R4 wrap ignored outside wrap mode", {30'd0, sts_rdata[10], sts_rdata[8]}, 32'h0);

    // Near-exhaustive sweep: enables x selection x mode x event set
    for (int e = 0; e < 8; e++) begin
      step(4'b0000, 4'h0, 1'b0, 1'b1, 3'(e), 1'b0, 32'h0);
      for (int s = 0; s < 16; s++) begin
        for (int m = 0; m < 2; m++) begin
          for (int v = 0; v < 16; v++) begin
            // event cycle, with a clear mask that collides on some flags
            step(4'(v), 4'(s), 1'(m), 1'b0, 3'(e), 1'b1,
                 {21'd0, v[3], 1'b0, v[2], 6'd0, v[1], v[0]} & {21'd0, 1'(s), 1'b0, 1'(m), 6'd0, 1'(e), 1'b1});
            // hold cycle so the registered interrupt reflects the flags
            step(4'b0000, 4'(s), 1'(m), 1'b0, 3'(e), 1'b0, 32'h0);
            // clear cycle with a partial mask derived from the indices
            step(4'b0000, 4'(s), 1'(m), 1'b0, 3'(e), 1'b1,
                 {21'd0, 1'(v + s), 1'b0, 1'(v + e), 6'd0, 1'(v >> 1), 1'(v + m)});
          end
        end
      end
    end

    done_run = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule